// File: doc/BRIEF.md
# Lane-Masked Dual-Port RAM

This block is a synchronous two-port memory wrapped around an inferred storage array. Both ports may read and write in every cycle. A write is split into lanes whose width is set by a parameter, which gives single-bit, nibble, byte or 9-bit granularity. A per-lane mask decides which lanes are written. The other lanes keep what they held.

Each port has a stall input. While it is high, the port keeps using the address it used on the previous edge, for reads and for writes, and ignores the address bus. Each port also has an asynchronous clear. It zeroes only that port's read-data registers, and never touches the stored words or the held address. A parameter selects whether one more output register follows the read register. Both ports share one clock. Reads are read-first: when a location is written on the same edge, from either port, the read returns the word from before that write.

Top module: `dpr_mask_ram`

## Requirements
- R1: Lane i of a word is bits [i*LANE_W +: LANE_W]. On a rising edge with write enable 1, lanes whose mask bit is 1 take the write data and lanes whose mask bit is 0 keep their contents. With write enable 0, nothing is stored.
- R2: While a port's stall input is 1 at a rising edge, that port reads and writes the address it used on the previous edge, whatever its address bus carries.
- R3: The stall inputs of the two ports act independently. A stall on one port does not change the address used by the other port.
- R4: With OUT_REG=0, the word at the address used on a rising edge appears on read data after that edge. With OUT_REG=1, it appears one rising edge later.
- R5: A port that writes and reads one address on the same edge returns the contents from before that write.
- R6: When one port reads an address that the other port writes on the same edge, the read returns the old contents.
- R7: When both ports write one address on the same edge, lanes enabled by only one port take that port's data. Lanes enabled by both take port B's data.
- R8: A port's clear, active high, forces that port's read data to zero at once without a clock edge, and keeps it at zero while held. Stored words and the held address are not changed by it.
- R9: A clear on one port leaves the other port's read data and behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| clr_a | input | 1 | Port A asynchronous clear of read-data registers |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| we_a | input | 1 | Port A write enable |
| mask_a | input | DATA_W/LANE_W | Port A lane write mask, 1 = write lane |
| stall_a | input | 1 | Port A address hold |
| rdata_a | output | DATA_W | Port A read data |
| clr_b | input | 1 | Port B asynchronous clear of read-data registers |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| we_b | input | 1 | Port B write enable |
| mask_b | input | DATA_W/LANE_W | Port B lane write mask, 1 = write lane |
| stall_b | input | 1 | Port B address hold |
| rdata_b | output | DATA_W | Port B read data |

## Verification
A wrong held address stays hidden until a stall edge. It then shows as a read or write at the wrong word, visible on read data one or two edges later, depending on OUT_REG. A bad lane merge or collision priority corrupts only the stored word, so it becomes visible only when that word is next read. The bench therefore drives addresses from a narrow range, which keeps re-reads and collisions frequent. A faulty clear shows at once as non-zero read data while the clear is high.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int unsigned DPR_PORTS = 2;

    function automatic int unsigned lane_count(input int unsigned data_w,
                                               input int unsigned lane_w);
        return data_w / lane_w;
    endfunction

endpackage

// File: rtl/dpr_lane_expand.sv
module dpr_lane_expand #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = DATA_W / LANE_W
) (
    input  logic              we,
    input  logic [LANES-1:0]  mask,
    output logic [DATA_W-1:0] bit_en
);

    // each mask bit widens to its lane's bit enables, gated by write enable
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bit_en[l*LANE_W +: LANE_W] = {LANE_W{we & mask[l]}};
    end

endmodule

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl #(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              stall,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rd,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] raw_d;

    always_comb begin
        addr_d = stall ? addr_q : addr;
        raw_d  = mem_rd;
    end

    assign eff_addr = addr_d;

    // address register: no clear
    always_ff @(posedge clk) begin
        addr_q <= addr_d;
    end

    // read register: sampled before the same-edge write lands
    always_ff @(posedge clk or posedge clr) begin
        if (clr) raw_q <= '0;
        else     raw_q <= raw_d;
    end

    if (OUT_REG) begin : g_oreg
        logic [DATA_W-1:0] out_d;
        logic [DATA_W-1:0] out_q;

        always_comb out_d = raw_q;

        always_ff @(posedge clk or posedge clr) begin
            if (clr) out_q <= '0;
            else     out_q <= out_d;
        end

        assign rdata = out_q;
    end else begin : g_nooreg
        assign rdata = raw_q;
    end

endmodule

// File: rtl/dpr_mem_array.sv
module dpr_mem_array
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic                                 clk,
    input  logic [DPR_PORTS-1:0][ADDR_W-1:0]     eff_addr,
    input  logic [DPR_PORTS-1:0][DATA_W-1:0]     bit_en,
    input  logic [DPR_PORTS-1:0][DATA_W-1:0]     wdata,
    output logic [DPR_PORTS-1:0][DATA_W-1:0]     rd
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DPR_PORTS-1:0][DATA_W-1:0] word_d;

    // merge: a higher port index builds on the lower ports' merged word
    always_comb begin
        for (int p = 0; p < DPR_PORTS; p++) begin
            logic [DATA_W-1:0] base;
            base = mem[eff_addr[p]];
            for (int q = 0; q < p; q++) begin
                if ((|bit_en[q]) && (eff_addr[q] == eff_addr[p])) base = word_d[q];
            end
            word_d[p] = (base & ~bit_en[p]) | (wdata[p] & bit_en[p]);
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < DPR_PORTS; p++) begin
            if (|bit_en[p]) mem[eff_addr[p]] <= word_d[p];
        end
    end

    for (genvar p = 0; p < DPR_PORTS; p++) begin : g_rd
        assign rd[p] = mem[eff_addr[p]];
    end

endmodule

// File: rtl/dpr_mask_ram.sv
module dpr_mask_ram
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LANE_W  = 8,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned LANES  = lane_count(DATA_W, LANE_W)
) (
    input  logic              clk,
    input  logic              clr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              we_a,
    input  logic [LANES-1:0]  mask_a,
    input  logic              stall_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              clr_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    input  logic              we_b,
    input  logic [LANES-1:0]  mask_b,
    input  logic              stall_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DPR_PORTS-1:0]              clr_v;
    logic [DPR_PORTS-1:0]              stall_v;
    logic [DPR_PORTS-1:0]              we_v;
    logic [DPR_PORTS-1:0][ADDR_W-1:0]  addr_v;
    logic [DPR_PORTS-1:0][ADDR_W-1:0]  eff_addr;
    logic [DPR_PORTS-1:0][LANES-1:0]   mask_v;
    logic [DPR_PORTS-1:0][DATA_W-1:0]  wdata_v;
    logic [DPR_PORTS-1:0][DATA_W-1:0]  bit_en;
    logic [DPR_PORTS-1:0][DATA_W-1:0]  mem_rd;
    logic [DPR_PORTS-1:0][DATA_W-1:0]  raw_q;
    logic [DPR_PORTS-1:0][DATA_W-1:0]  rdata_v;

    assign clr_v   = {clr_b,   clr_a};
    assign stall_v = {stall_b, stall_a};
    assign we_v    = {we_b,    we_a};
    assign addr_v  = {addr_b,  addr_a};
    assign mask_v  = {mask_b,  mask_a};
    assign wdata_v = {wdata_b, wdata_a};
    assign rdata_a = rdata_v[0];
    assign rdata_b = rdata_v[1];

    for (genvar p = 0; p < DPR_PORTS; p++) begin : g_port
        dpr_lane_expand #(
            .DATA_W (DATA_W),
            .LANE_W (LANE_W),
            .LANES  (LANES)
        ) u_exp (
            .we     (we_v[p]),
            .mask   (mask_v[p]),
            .bit_en (bit_en[p])
        );

        dpr_port_ctl #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .OUT_REG (OUT_REG)
        ) u_ctl (
            .clk      (clk),
            .clr      (clr_v[p]),
            .stall    (stall_v[p]),
            .addr     (addr_v[p]),
            .mem_rd   (mem_rd[p]),
            .eff_addr (eff_addr[p]),
            .raw_q    (raw_q[p]),
            .rdata    (rdata_v[p])
        );
    end

    dpr_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk      (clk),
        .eff_addr (eff_addr),
        .bit_en   (bit_en),
        .wdata    (wdata_v),
        .rd       (mem_rd)
    );

endmodule

// File: rtl/dpr_mask_ram_chk.sv
module dpr_mask_ram_chk #(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              clr_a,
    input logic              clr_b,
    input logic              stall_a,
    input logic              stall_b,
    input logic [ADDR_W-1:0] eff_a,
    input logic [ADDR_W-1:0] eff_b,
    input logic [DATA_W-1:0] mrd_a,
    input logic [DATA_W-1:0] mrd_b,
    input logic [DATA_W-1:0] raw_a,
    input logic [DATA_W-1:0] raw_b,
    input logic [DATA_W-1:0] rdata_a,
    input logic [DATA_W-1:0] rdata_b
);

    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // R2
    hold_addr_a_chk: assert property (@(posedge clk) disable iff (!armed_q)
        stall_a |-> eff_a == $past(eff_a));
    // R2
    hold_addr_b_chk: assert property (@(posedge clk) disable iff (!armed_q)
        stall_b |-> eff_b == $past(eff_b));

    // R5
    read_first_a_chk: assert property (@(posedge clk) disable iff (!armed_q || clr_a)
        1'b1 |=> raw_a == $past(mrd_a));
    // R6
    read_first_b_chk: assert property (@(posedge clk) disable iff (!armed_q || clr_b)
        1'b1 |=> raw_b == $past(mrd_b));

    // R8
    clear_zero_a_chk: assert property (@(posedge clk) disable iff (!armed_q)
        clr_a |-> rdata_a == '0);
    // R8
    clear_zero_b_chk: assert property (@(posedge clk) disable iff (!armed_q)
        clr_b |-> rdata_b == '0);

    if (OUT_REG) begin : g_lat
        // R4
        out_stage_a_chk: assert property (@(posedge clk) disable iff (!armed_q || clr_a)
            1'b1 |=> rdata_a == $past(raw_a));
        // R4
        out_stage_b_chk: assert property (@(posedge clk) disable iff (!armed_q || clr_b)
            1'b1 |=> rdata_b == $past(raw_b));
    end

endmodule

bind dpr_mask_ram dpr_mask_ram_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk     (clk),
    .clr_a   (clr_a),
    .clr_b   (clr_b),
    .stall_a (stall_a),
    .stall_b (stall_b),
    .eff_a   (eff_addr[0]),
    .eff_b   (eff_addr[1]),
    .mrd_a   (mem_rd[0]),
    .mrd_b   (mem_rd[1]),
    .raw_a   (raw_q[0]),
    .raw_b   (raw_q[1]),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
);

// File: tb/dpr_mask_ram_tb.sv
module dpr_mask_ram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 36;
    localparam int LW    = 9;
    localparam int NL    = DW / LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [AW-1:0] d_addr [2];
    logic [DW-1:0] d_wd   [2];
    logic          d_we   [2];
    logic [NL-1:0] d_m    [2];
    logic          d_st   [2];
    logic          d_clr  [2];
    logic [DW-1:0] r1     [2];
    logic [DW-1:0] r0     [2];

    dpr_mask_ram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .OUT_REG(1'b1)) dut_i (
        .clk(clk),
        .clr_a(d_clr[0]), .addr_a(d_addr[0]), .wdata_a(d_wd[0]), .we_a(d_we[0]),
        .mask_a(d_m[0]), .stall_a(d_st[0]), .rdata_a(r1[0]),
        .clr_b(d_clr[1]), .addr_b(d_addr[1]), .wdata_b(d_wd[1]), .we_b(d_we[1]),
        .mask_b(d_m[1]), .stall_b(d_st[1]), .rdata_b(r1[1]));

    dpr_mask_ram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .OUT_REG(1'b0)) dut0_i (
        .clk(clk),
        .clr_a(d_clr[0]), .addr_a(d_addr[0]), .wdata_a(d_wd[0]), .we_a(d_we[0]),
        .mask_a(d_m[0]), .stall_a(d_st[0]), .rdata_a(r0[0]),
        .clr_b(d_clr[1]), .addr_b(d_addr[1]), .wdata_b(d_wd[1]), .we_b(d_we[1]),
        .mask_b(d_m[1]), .stall_b(d_st[1]), .rdata_b(r0[1]));

    // reference model
    logic [DW-1:0] mdl [DEPTH];
    bit            vld [DEPTH];
    logic [AW-1:0] hold [2];
    logic [DW-1:0] raw_e [2];
    bit            raw_ok [2];
    logic [DW-1:0] out_e [2];
    bit            out_ok [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [DW-1:0] expand(input logic [NL-1:0] m);
        logic [DW-1:0] e;
        for (int l = 0; l < NL; l++) e[l*LW +: LW] = {LW{m[l]}};
        return e;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom(), $urandom()} & {DW{1'b1}};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        for (int p = 0; p < 2; p++) begin
            if (raw_ok[p]) chk(tag, r0[p], raw_e[p]);
            if (out_ok[p]) chk(tag, r1[p], out_e[p]);
        end
    endtask

    task automatic tick(input string tag);
        logic [AW-1:0] eff [2];
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            eff[p] = d_st[p] ? hold[p] : d_addr[p];
            if (d_clr[p]) begin
                out_e[p] = '0; out_ok[p] = 1'b1;
                raw_e[p] = '0; raw_ok[p] = 1'b1;
            end else begin
                out_e[p] = raw_e[p]; out_ok[p] = raw_ok[p];
                raw_e[p] = mdl[eff[p]]; raw_ok[p] = vld[eff[p]];
            end
        end
        // port B applied last: B wins on shared lanes
        for (int p = 0; p < 2; p++) begin
            if (d_we[p]) begin
                logic [DW-1:0] bm;
                bm = expand(d_m[p]);
                mdl[eff[p]] = (mdl[eff[p]] & ~bm) | (d_wd[p] & bm);
                if (&d_m[p]) vld[eff[p]] = 1'b1;
            end
            hold[p] = eff[p];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_clr(input int p, input bit v);
        d_clr[p] = v;
        if (v) begin
            #1;
            raw_e[p] = '0; raw_ok[p] = 1'b1;
            out_e[p] = '0; out_ok[p] = 1'b1;
            chk("R8 async clear rdata0", r0[p], '0);
            chk("R8 async clear rdata1", r1[p], '0);
            // other port untouched
            if (raw_ok[1-p]) chk("R9 other port rdata0", r0[1-p], raw_e[1-p]);
            if (out_ok[1-p]) chk("R9 other port rdata1", r1[1-p], out_e[1-p]);
        end
    endtask

    task automatic idle();
        for (int p = 0; p < 2; p++) begin
            d_we[p] = 1'b0; d_st[p] = 1'b0; d_m[p] = '0; d_wd[p] = '0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin mdl[i] = '0; vld[i] = 1'b0; end
        for (int p = 0; p < 2; p++) begin
            d_addr[p] = '0; d_clr[p] = 1'b1; hold[p] = '0;
            raw_e[p] = '0; raw_ok[p] = 1'b1; out_e[p] = '0; out_ok[p] = 1'b1;
        end
        idle();
        #1;
        // reset state: clears held from time zero
        compare("R8 reset state");
        @(negedge clk);
        tick("R8 clear held over edge");
        d_clr[0] = 1'b0; d_clr[1] = 1'b0;

        // fill every word with full-mask writes
        for (int i = 0; i < DEPTH / 2; i++) begin
            d_addr[0] = AW'(2 * i); d_addr[1] = AW'(2 * i + 1);
            d_we[0] = 1'b1; d_we[1] = 1'b1; d_m[0] = '1; d_m[1] = '1;
            d_wd[0] = rnd_word(); d_wd[1] = rnd_word();
            tick("R1 fill");
        end
        idle();

        // R1: lanes 0 and 2 only
        d_addr[0] = 6'd3; d_we[0] = 1'b1; d_m[0] = 4'b0101; d_wd[0] = '1;
        tick("R1 masked write");
        idle(); d_addr[0] = 6'd3; d_addr[1] = 6'd3;
        tick("R1 readback"); tick("R1 readback");
        // R1: write enable low stores nothing
        d_addr[0] = 6'd3; d_we[0] = 1'b0; d_m[0] = '1; d_wd[0] = '0;
        tick("R1 we low"); idle(); tick("R1 we low"); tick("R1 we low");

        // R5: same-port write and read
        d_addr[0] = 6'd4; d_we[0] = 1'b1; d_m[0] = '1; d_wd[0] = 36'h1_2345_6789;
        tick("R5 same port old data");
        idle(); d_addr[0] = 6'd4;
        tick("R5 new data"); tick("R5 new data");

        // R6: A reads while B writes
        d_addr[0] = 6'd5; d_addr[1] = 6'd5; d_we[1] = 1'b1; d_m[1] = '1;
        d_wd[1] = 36'hA_5A5A_5A5A;
        tick("R6 cross port old data");
        idle(); tick("R6 cross port new data"); tick("R6 cross port new data");

        // R7: both write word 6
        d_addr[0] = 6'd6; d_addr[1] = 6'd6;
        d_we[0] = 1'b1; d_m[0] = 4'b0011; d_wd[0] = 36'h1_1111_1111;
        d_we[1] = 1'b1; d_m[1] = 4'b0110; d_wd[1] = 36'h2_2222_2222;
        tick("R7 double write");
        idle(); tick("R7 merged word"); tick("R7 merged word");

        // R2 and R3: A holds 7 while B moves
        d_addr[0] = 6'd7; d_addr[1] = 6'd8;
        tick("R2 set address");
        d_st[0] = 1'b1; d_addr[0] = 6'd9; d_we[0] = 1'b1; d_m[0] = 4'b1000;
        d_wd[0] = '0; d_addr[1] = 6'd9;
        tick("R3 B not held");
        d_we[0] = 1'b0; d_addr[0] = 6'd10;
        tick("R2 write went to held word");
        d_st[1] = 1'b1; d_addr[1] = 6'd11; d_st[0] = 1'b0;
        tick("R3 B held A free");
        idle(); tick("R2 release"); tick("R2 release");

        // R8 and R9: clear port A, B keeps running
        d_addr[0] = 6'd12; d_addr[1] = 6'd13;
        tick("R8 before clear");
        set_clr(0, 1'b1);
        d_addr[1] = 6'd14;
        tick("R8 clear held"); tick("R9 B during A clear");
        set_clr(0, 1'b0);
        tick("R8 after release"); tick("R8 after release");
        set_clr(1, 1'b1);
        tick("R9 B cleared");
        set_clr(1, 1'b0);

        // R4: latency on a changing read sequence
        for (int i = 0; i < 6; i++) begin
            d_addr[0] = AW'(i * 5); d_addr[1] = AW'(i * 7);
            tick("R4 latency");
        end

        // random phase, narrow address range for collisions
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < 2; p++) begin
                d_addr[p] = AW'($urandom() % 8);
                d_we[p]   = ($urandom() % 2) == 0;
                d_m[p]    = NL'($urandom());
                d_wd[p]   = rnd_word();
                d_st[p]   = ($urandom() % 4) == 0;
                if (d_clr[p]) set_clr(p, 1'b0);
                else if (($urandom() % 60) == 0) set_clr(p, 1'b1);
            end
            tick("R1 random");
        end
        idle();
        set_clr(0, 1'b0); set_clr(1, 1'b0);
        tick("R4 drain"); tick("R4 drain");
        finish_run();
    end

endmodule